// File: doc/BRIEF.md
# Dynamic Shift-Round-Rectify Scaler

This block conditions a stream of two's complement samples before they leave a datapath. Every clock cycle it may accept one sample together with its own signed offset, a shift magnitude, a shift direction and a rectification mode. It first adds the offset to the sample. It then shifts the sum arithmetically left or right. On a right shift it rounds by adding half of the result LSB and truncating. Last, the result either passes through unchanged, is full-wave rectified or is half-wave rectified. All controls belong to the sample presented with them, so a different scaling can be applied to every sample in a back-to-back stream.

The pipeline has two register stages. The first stage holds the offset-and-shift partial result. The second stage holds the rounded and rectified output. A valid flag travels with the data. No arithmetic overflow is detected: left shifts, the offset addition and negation of the most negative value all wrap modulo 2^16.

Top module: `dsr_scaler`

## Requirements
- R1: `out_valid` equals the `in_valid` that was sampled two rising edges earlier. Both `out_valid` and `out_data` read 0 while `rst_n` is low and after a reset, until new valid samples reach the output.
- R2: The offset is added to the sample before any shift. The 16-bit sum wraps on overflow (0x7FFF + 0x0001 = 0x8000).
- R3: With `shift_left` = 0, the shift is arithmetic and the sign bit fills every vacated high bit (0xC500 shifted right by 2 gives 0xF140).
- R4: A right shift by n ≥ 1 adds 2^(n-1) to the sum and then truncates, so ties round toward positive infinity. Examples: -2>>2 gives 0, 2>>2 gives 1, -3>>2 gives -1, 1>>2 gives 0, 0x7FFF>>1 gives 0x4000.
- R5: With `shift_left` = 1, the vacated low bits are filled with zeros and no rounding is applied. Overflow wraps without any indication (0x4001 shifted left by 1 gives 0x8002).
- R6: A shift magnitude of 0 passes the offset sum through in either direction, with no rounding.
- R7: `rect_mode` encoding: 0 and 3 pass the value unchanged, 1 negates negative values (full-wave), 2 replaces negative values with zero (half-wave). Zero and positive values are unchanged in every mode.
- R8: Full-wave rectification of 0x8000 gives 0x8000.
- R9: Offset, shift and mode may change on every cycle. Each one applies only to the sample presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample and controls are valid this cycle |
| in_sample | input | 16 | Signed input sample |
| in_offset | input | 16 | Signed offset added before the shift |
| shift_amt | input | 4 | Shift magnitude, 0 to 15 |
| shift_left | input | 1 | 1 = left shift, 0 = rounded right shift |
| rect_mode | input | 2 | 0/3 pass, 1 full-wave, 2 half-wave |
| out_valid | output | 1 | Output sample is valid |
| out_data | output | 16 | Scaled, rounded and rectified sample |

## Verification
The properties take the control inputs to be stable and known in any cycle where `in_valid` is high. They also assume that a shift magnitude never exceeds 15, which the 4-bit port enforces. They compare only cycles that carry a valid sample, so the data outputs can be left at any value during bubbles. The stimulus drives every input only on falling clock edges and changes all controls together with each sample. It includes deliberate idle cycles and a reset in the middle of the stream, so that the valid-tracking properties see both flag values.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Output conditioning selector; two codes map to plain pass-through.
    typedef enum logic [1:0] {
        RECT_PASS     = 2'd0,
        RECT_FULL     = 2'd1,
        RECT_HALF     = 2'd2,
        RECT_PASS_ALT = 2'd3
    } rect_mode_e;

endpackage

// File: rtl/dsr_shift_stage.sv
module dsr_shift_stage #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_sample,
    input  logic [DATA_W-1:0]    in_offset,
    input  logic [SHAMT_W-1:0]   shift_amt,
    input  logic                 shift_left,
    input  dsr_pkg::rect_mode_e  rect_mode,
    output logic                 s1_valid,
    output logic [DATA_W:0]      s1_acc,
    output logic                 s1_rnd,
    output dsr_pkg::rect_mode_e  s1_mode
);
    import dsr_pkg::*;

    localparam logic [SHAMT_W-1:0] AMT_ONE = {{(SHAMT_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0]        sum;
    logic signed [DATA_W:0]   sum_ext;
    logic [DATA_W-1:0]        shl;
    logic [DATA_W:0]          acc_d;
    logic                     rnd_d;

    // Offset first, wrapping at the data width (R2).
    assign sum     = in_sample + in_offset;
    assign sum_ext = $signed({sum[DATA_W-1], sum});
    assign shl     = sum << shift_amt;

    // The partial result keeps one extra fraction bit. A right shift by n
    // stops at n-1 so that the next stage adds the half-LSB there.
    always_comb begin
        if (shift_left) begin
            acc_d = {shl, 1'b0};
            rnd_d = 1'b0;
        end else if (shift_amt == '0) begin
            acc_d = {sum, 1'b0};
            rnd_d = 1'b0;
        end else begin
            acc_d = sum_ext >>> (shift_amt - AMT_ONE);
            rnd_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_acc   <= '0;
            s1_rnd   <= 1'b0;
            s1_mode  <= RECT_PASS;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_acc  <= acc_d;
                s1_rnd  <= rnd_d;
                s1_mode <= rect_mode;
            end
        end
    end

endmodule

// File: rtl/dsr_round_unit.sv
module dsr_round_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W:0]   acc,
    input  logic              rnd,
    output logic [DATA_W-1:0] rounded
);
    logic [DATA_W:0] acc_plus;

    // The add is done at full partial width, so a carry cannot reach the sign.
    assign acc_plus = acc + {{DATA_W{1'b0}}, rnd};
    assign rounded  = acc_plus[DATA_W:1];

endmodule

// File: rtl/dsr_rectify.sv
module dsr_rectify #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]    x,
    input  dsr_pkg::rect_mode_e  mode,
    output logic [DATA_W-1:0]    y
);
    import dsr_pkg::*;

    logic neg;
    assign neg = x[DATA_W-1];

    always_comb begin
        unique case (mode)
            RECT_FULL:     y = neg ? (~x + {{(DATA_W-1){1'b0}}, 1'b1}) : x;
            RECT_HALF:     y = neg ? '0 : x;
            RECT_PASS,
            RECT_PASS_ALT: y = x;
        endcase
    end

endmodule

// File: rtl/dsr_scaler.sv
module dsr_scaler #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_sample,
    input  logic [DATA_W-1:0]  in_offset,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               shift_left,
    input  logic [1:0]         rect_mode,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    import dsr_pkg::*;

    logic              s1_valid;
    logic [DATA_W:0]   s1_acc;
    logic              s1_rnd;
    rect_mode_e        s1_mode;
    logic [DATA_W-1:0] rounded;
    logic [DATA_W-1:0] rectified;

    dsr_shift_stage #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_offset  (in_offset),
        .shift_amt  (shift_amt),
        .shift_left (shift_left),
        .rect_mode  (rect_mode_e'(rect_mode)),
        .s1_valid   (s1_valid),
        .s1_acc     (s1_acc),
        .s1_rnd     (s1_rnd),
        .s1_mode    (s1_mode)
    );

    dsr_round_unit #(.DATA_W(DATA_W)) u_round (
        .acc     (s1_acc),
        .rnd     (s1_rnd),
        .rounded (rounded)
    );

    dsr_rectify #(.DATA_W(DATA_W)) u_rect (
        .x    (rounded),
        .mode (s1_mode),
        .y    (rectified)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= rectified;
            end
        end
    end

endmodule

// File: rtl/dsr_scaler_chk.sv
module dsr_scaler_chk #(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [DATA_W-1:0]  in_sample,
    input logic [DATA_W-1:0]  in_offset,
    input logic [SHAMT_W-1:0] shift_amt,
    input logic               shift_left,
    input logic [1:0]         rect_mode,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_data
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONE_D    = {{(DATA_W-1){1'b0}}, 1'b1};

    // Checker-side record of each sample's controls, two cycles deep.
    logic               v1, v2;
    logic [DATA_W-1:0]  sum1, sum2;
    logic [SHAMT_W-1:0] amt1, amt2;
    logic               lft1, lft2;
    logic [1:0]         md1, md2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            sum1 <= '0; sum2 <= '0;
            amt1 <= '0; amt2 <= '0;
            lft1 <= 1'b0; lft2 <= 1'b0;
            md1 <= '0; md2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            sum1 <= in_sample + in_offset; sum2 <= sum1;
            amt1 <= shift_amt; amt2 <= amt1;
            lft1 <= shift_left; lft2 <= lft1;
            md1 <= rect_mode; md2 <= md1;
        end
    end

    logic              pass2;
    logic [DATA_W-1:0] low_mask2;
    assign pass2     = (md2 == 2'd0) || (md2 == 2'd3);
    assign low_mask2 = (ONE_D << amt2) - ONE_D;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    assert_zero_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pass2 && amt2 == '0) |-> out_data == sum2);

    assert_sign_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pass2 && !lft2 && sum2[DATA_W-1]) |-> (out_data[DATA_W-1] || out_data == '0));

    assert_left_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pass2 && lft2) |-> (out_data & low_mask2) == '0);

    assert_half_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md2 == 2'd2) |-> !out_data[DATA_W-1]);

    assert_full_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && md2 == 2'd1 && out_data[DATA_W-1]) |-> out_data == MOST_NEG);

endmodule

bind dsr_scaler dsr_scaler_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_offset  (in_offset),
    .shift_amt  (shift_amt),
    .shift_left (shift_left),
    .rect_mode  (rect_mode),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/dsr_scaler_bench.sv
`timescale 1ns/1ps
module dsr_scaler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [15:0] in_offset = '0;
    logic [3:0]  shift_amt = '0;
    logic        shift_left = 1'b0;
    logic [1:0]  rect_mode = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dsr_scaler u_dsr_scaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_offset  (in_offset),
        .shift_amt  (shift_amt),
        .shift_left (shift_left),
        .rect_mode  (rect_mode),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // {sample, offset, left, amt, mode, expected}
    localparam int NV = 18;
    localparam logic [54:0] VEC [NV] = '{
        {16'hC500, 16'h0000, 1'b0, 4'd2,  2'd0, 16'hF140}, // R3 sign fill
        {16'hFFFE, 16'h0000, 1'b0, 4'd2,  2'd0, 16'h0000}, // R4 tie up
        {16'h0002, 16'h0000, 1'b0, 4'd2,  2'd0, 16'h0001}, // R4 tie up
        {16'hFFFD, 16'h0000, 1'b0, 4'd2,  2'd0, 16'hFFFF}, // R4 below half
        {16'h0001, 16'h0000, 1'b0, 4'd2,  2'd0, 16'h0000}, // R4 below half
        {16'h0064, 16'hFFCE, 1'b0, 4'd1,  2'd0, 16'h0019}, // R2 offset then shift
        {16'h7FFF, 16'h0001, 1'b0, 4'd0,  2'd0, 16'h8000}, // R2 wrap
        {16'h4001, 16'h0000, 1'b1, 4'd1,  2'd0, 16'h8002}, // R5 overflow wraps
        {16'h0003, 16'h0000, 1'b1, 4'd4,  2'd0, 16'h0030}, // R5 zero fill
        {16'h1235, 16'h0000, 1'b0, 4'd0,  2'd0, 16'h1235}, // R6 no rounding
        {16'hFF00, 16'h0000, 1'b0, 4'd0,  2'd1, 16'h0100}, // R7 full-wave
        {16'hFF00, 16'h0000, 1'b0, 4'd0,  2'd2, 16'h0000}, // R7 half-wave
        {16'h0123, 16'h0000, 1'b0, 4'd0,  2'd2, 16'h0123}, // R7 positive kept
        {16'h8000, 16'h0000, 1'b0, 4'd0,  2'd1, 16'h8000}, // R8 negate wraps
        {16'hFFF0, 16'h0000, 1'b1, 4'd0,  2'd3, 16'hFFF0}, // R7 code 3, R6 left 0
        {16'h7FFF, 16'h0000, 1'b0, 4'd1,  2'd0, 16'h4000}, // R4 most positive
        {16'hFFFA, 16'h0000, 1'b0, 4'd1,  2'd1, 16'h0003}, // R4 with R7 full
        {16'h8000, 16'h0000, 1'b0, 4'd15, 2'd0, 16'hFFFF}  // R3 max shift
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [54:0] v);
        in_valid   = 1'b1;
        in_sample  = v[54:39];
        in_offset  = v[38:23];
        shift_left = v[22];
        shift_amt  = v[21:18];
        rect_mode  = v[17:16];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {15'd0, out_valid}, 16'd0);
        check("R1 reset data", out_data, 16'h0000);
        rst_n = 1'b1;

        // Back-to-back stream, new controls every cycle (R9).
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check($sformatf("R9 vector %0d valid", i - 2), {15'd0, out_valid}, 16'd1);
                check($sformatf("R9 vector %0d data", i - 2), out_data, VEC[i-2][15:0]);
            end
            if (i < NV) drive(VEC[i]);
            else in_valid = 1'b0;
        end

        // Bubble handling, R1.
        @(negedge clk);
        check("R1 idle", {15'd0, out_valid}, 16'd0);
        drive({16'h0010, 16'h0000, 1'b0, 4'd3, 2'd0, 16'h0002});
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 one cycle in", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        check("R1 two cycles in", {15'd0, out_valid}, 16'd1);
        check("R4 0x10>>3", out_data, 16'h0002);
        @(negedge clk);
        check("R1 single pulse", {15'd0, out_valid}, 16'd0);

        // Reset in mid-stream, R1.
        drive({16'h0100, 16'h0000, 1'b0, 4'd0, 2'd0, 16'h0100});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", {15'd0, out_valid}, 16'd0);
        check("R1 mid reset data", out_data, 16'h0000);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {15'd0, out_valid}, 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule